// File: doc/BRIEF.md
# Dynamic Two-Kernel SM Allocator

This block hands out cooperative thread arrays (CTAs) from two kernels that run at the same time. The targets are a pool of streaming multiprocessors (SMs), eight by default. A start pulse loads each kernel's total CTA count. The block then keeps two kinds of count: how many CTAs of each kernel are still waiting, and how many CTAs are resident on each SM. One dispatch per cycle goes out on a valid/ready handshake, tagged with a kernel identifier and an SM index. Each SM returns a completion pulse for every CTA it retires.

Ownership starts as an even split. As a kernel's waiting count falls, it gives up SMs one at a time. A released SM stops receiving CTAs but finishes the ones it holds. Once it is empty it moves to the other kernel, so the kernel with more work left gradually takes over the pool. A done flag reports when no CTA is waiting or resident anywhere.

Top module: `dyn_sm_alloc`

## Requirements
- R1: Under reset and on every start pulse, SMs 0 to 3 belong to kernel 0 and SMs 4 to 7 belong to kernel 1. Bit i of `sm_owner` is the owner of SM i (1 means kernel 1), so the pattern reads 8'hF0. Start also opens every SM and loads both waiting counts.
- R2: An SM never holds more than 8 resident CTAs, and no dispatch is offered to an SM that is full.
- R3: A dispatch with `disp_kid` = k and `disp_sm` = i is offered only when SM i belongs to kernel k and is open (bit i of `sm_open` is 1).
- R4: Within one kernel, dispatches rotate across its eligible SMs in rising index order. The rotation wraps around, and after a start it begins at the kernel's lowest-indexed SM.
- R5: When both kernels have an eligible SM, the kernel that was not served by the previous accepted dispatch wins. Kernel 0 wins first after a start.
- R6: Take a kernel with n > 1 open SMs and a nonzero waiting count equal to 8·(1+2+…+(n−1)), which is 48 for n = 4 and 24 for n = 3. One clock edge later, its highest-indexed open SM is closed.
- R7: A closed SM with zero resident CTAs passes to the other kernel and reopens on the next edge, provided the other kernel still has CTAs waiting.
- R8: A kernel whose waiting count is zero closes all of its SMs. While its waiting count is nonzero, it always keeps at least one open SM.
- R9: A completion pulse and an accepted dispatch to the same SM in the same cycle leave that SM's resident count unchanged. A completion pulse to an empty SM is ignored.
- R10: `all_done` is high exactly when both waiting counts are zero and every SM holds zero resident CTAs. Each kernel receives exactly as many dispatches as its loaded total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Load both totals and restore the initial ownership |
| total_k0 | input | 16 | CTA total of kernel 0, sampled on start |
| total_k1 | input | 16 | CTA total of kernel 1, sampled on start |
| disp_valid | output | 1 | A dispatch is offered |
| disp_ready | input | 1 | The offered dispatch is accepted this cycle |
| disp_kid | output | 1 | Kernel of the offered CTA |
| disp_sm | output | 3 | Target SM of the offered CTA |
| sm_done | input | 8 | One pulse per retired CTA, bit i for SM i |
| sm_owner | output | 8 | Current owner kernel per SM |
| sm_open | output | 8 | SM accepts new CTAs from its owner |
| all_done | output | 1 | No CTA waiting or resident |

## Verification
The dispatch outputs and `all_done` are decoded from registered state. They are therefore valid in the same cycle as the state they reflect, and an accepted handshake changes the counts at the next rising edge. A threshold crossing closes an SM one edge after the waiting count lands on the threshold. The hand-over to the other kernel follows one edge after that, so the bench checks ownership exactly two and three edges after the triggering dispatch. All inputs are driven, and all outputs sampled, at the falling edge. The bench keeps its own per-SM resident model and per-kernel dispatch tallies from the handshakes it observes, and sweeps a grid of total pairs under random back-pressure and random completions.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef enum logic {KID_A = 1'b0, KID_B = 1'b1} kid_e;

  // Waiting-count level at which a kernel holding n SMs gives one up.
  function automatic int shrink_level(input int n, input int cap);
    return (cap * n * (n - 1)) / 2;
  endfunction

endpackage

// File: rtl/dsa_rr_pick.sv
module dsa_rr_pick #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  input  logic [IDXW-1:0] last,
  output logic [IDXW-1:0] pick,
  output logic            any
);

  // Scan from the far offset down so the nearest request after `last` wins.
  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int off = N; off >= 1; off--) begin
      if (req[(int'(last) + off) % N]) begin
        pick = IDXW'((int'(last) + off) % N);
        any  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dsa_kernel_ctrl.sv
module dsa_kernel_ctrl #(
  parameter int NUM_SM   = 8,
  parameter int SLOT_MAX = 8,
  parameter int CNT_W    = 16,
  parameter int NCNT_W   = $clog2(NUM_SM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  load_total,
  input  logic              take,
  input  logic [NCNT_W-1:0] own_n,
  output logic [CNT_W-1:0]  pending,
  output logic              shrink_req,
  output logic              drain_all
);

  localparam int TAB_N = 1 << NCNT_W;

  logic [CNT_W-1:0] lvl_tab [TAB_N];
  logic [CNT_W-1:0] pend_nxt;
  logic             pend_en;

  generate
    for (genvar n = 0; n < TAB_N; n++) begin : g_lvl
      if (n <= NUM_SM) begin : g_live
        assign lvl_tab[n] = CNT_W'(dsa_pkg::shrink_level(n, SLOT_MAX));
      end else begin : g_pad
        assign lvl_tab[n] = '0;
      end
    end
  endgenerate

  assign shrink_req = (own_n > NCNT_W'(1)) && (pending != '0) &&
                      (pending == lvl_tab[own_n]);
  assign drain_all  = (pending == '0);

  always_comb begin
    pend_en  = start | take;
    pend_nxt = pending;
    if (start) begin
      pend_nxt = load_total;
    end else if (take) begin
      pend_nxt = pending - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (pend_en) begin
      pending <= pend_nxt;
    end
  end

endmodule

// File: rtl/dsa_sm_slot.sv
module dsa_sm_slot #(
  parameter int   SLOT_MAX   = 8,
  parameter int   RES_W      = $clog2(SLOT_MAX + 1),
  parameter logic INIT_OWNER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             add,
  input  logic             retire,
  input  logic             close,
  input  logic [1:0]       has_work,
  output logic             owner,
  output logic             open,
  output logic [RES_W-1:0] res
);

  logic             owner_nxt, open_nxt, own_en;
  logic [RES_W-1:0] res_nxt;
  logic             res_en, dec;

  always_comb begin
    owner_nxt = owner;
    open_nxt  = open;
    if (start) begin
      owner_nxt = INIT_OWNER;
      open_nxt  = 1'b1;
    end else if (close) begin
      open_nxt  = 1'b0;
    end else if (!open && (res == '0) && has_work[~owner]) begin
      owner_nxt = ~owner;
      open_nxt  = 1'b1;
    end
    own_en = (owner_nxt != owner) || (open_nxt != open);
  end

  always_comb begin
    dec     = retire && (res != '0);
    res_en  = add ^ dec;
    res_nxt = res;
    if (add && !dec) begin
      res_nxt = res + RES_W'(1);
    end else if (dec && !add) begin
      res_nxt = res - RES_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= INIT_OWNER;
      open  <= 1'b1;
    end else if (own_en) begin
      owner <= owner_nxt;
      open  <= open_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
    end else if (res_en) begin
      res <= res_nxt;
    end
  end

endmodule

// File: rtl/dyn_sm_alloc.sv
module dyn_sm_alloc #(
  parameter int NUM_SM   = 8,
  parameter int SLOT_MAX = 8,
  parameter int CNT_W    = 16,
  parameter int SM_W     = $clog2(NUM_SM),
  parameter int RES_W    = $clog2(SLOT_MAX + 1),
  parameter int NCNT_W   = $clog2(NUM_SM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  total_k0,
  input  logic [CNT_W-1:0]  total_k1,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic              disp_kid,
  output logic [SM_W-1:0]   disp_sm,
  input  logic [NUM_SM-1:0] sm_done,
  output logic [NUM_SM-1:0] sm_owner,
  output logic [NUM_SM-1:0] sm_open,
  output logic              all_done
);

  localparam int HALF = NUM_SM / 2;

  logic [CNT_W-1:0]        pend     [2];
  logic [CNT_W-1:0]        load_tot [2];
  logic [NCNT_W-1:0]       own_n    [2];
  logic [NUM_SM-1:0]       oo_mask  [2];
  logic [NUM_SM-1:0]       elig     [2];
  logic [SM_W-1:0]         pick     [2];
  logic [SM_W-1:0]         last     [2];
  logic [SM_W-1:0]         last_nxt [2];
  logic [SM_W-1:0]         hi_idx   [2];
  logic [1:0]              any, shrink, drain, has_work, take;
  logic [RES_W-1:0]        res      [NUM_SM];
  logic [NUM_SM*RES_W-1:0] res_flat;
  logic [NUM_SM-1:0]       not_full, add, close;
  logic [CNT_W-1:0]        pend_k0, pend_k1;
  logic                    prio, prio_nxt, prio_en, hs;

  assign load_tot[0] = total_k0;
  assign load_tot[1] = total_k1;
  assign pend_k0     = pend[0];
  assign pend_k1     = pend[1];

  assign oo_mask[0] = ~sm_owner & sm_open;
  assign oo_mask[1] =  sm_owner & sm_open;

  generate
    for (genvar k = 0; k < 2; k++) begin : g_kern
      assign own_n[k]    = NCNT_W'($countones(oo_mask[k]));
      assign has_work[k] = (pend[k] != '0);
      assign elig[k]     = oo_mask[k] & not_full & {NUM_SM{has_work[k]}};
      assign take[k]     = hs && (disp_kid == k[0]);

      dsa_kernel_ctrl #(
        .NUM_SM(NUM_SM), .SLOT_MAX(SLOT_MAX), .CNT_W(CNT_W), .NCNT_W(NCNT_W)
      ) u_kctl (
        .clk(clk), .rst_n(rst_n), .start(start), .load_total(load_tot[k]),
        .take(take[k]), .own_n(own_n[k]), .pending(pend[k]),
        .shrink_req(shrink[k]), .drain_all(drain[k])
      );

      dsa_rr_pick #(.N(NUM_SM), .IDXW(SM_W)) u_pick (
        .req(elig[k]), .last(last[k]), .pick(pick[k]), .any(any[k])
      );

      always_comb begin
        hi_idx[k] = '0;
        for (int i = 0; i < NUM_SM; i++) begin
          if (oo_mask[k][i]) hi_idx[k] = SM_W'(i);
        end
      end

      always_comb begin
        last_nxt[k] = last[k];
        if (start) begin
          last_nxt[k] = SM_W'(NUM_SM - 1);
        end else if (take[k]) begin
          last_nxt[k] = pick[k];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          last[k] <= SM_W'(NUM_SM - 1);
        end else if (start || take[k]) begin
          last[k] <= last_nxt[k];
        end
      end
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_SM; i++) begin : g_sm
      assign not_full[i] = (res[i] < RES_W'(SLOT_MAX));
      assign add[i]      = hs && (disp_sm == SM_W'(i));
      assign close[i]    =
        (oo_mask[0][i] && (drain[0] || (shrink[0] && hi_idx[0] == SM_W'(i)))) ||
        (oo_mask[1][i] && (drain[1] || (shrink[1] && hi_idx[1] == SM_W'(i))));
      assign res_flat[i*RES_W +: RES_W] = res[i];

      dsa_sm_slot #(
        .SLOT_MAX(SLOT_MAX), .RES_W(RES_W), .INIT_OWNER(i >= HALF)
      ) u_slot (
        .clk(clk), .rst_n(rst_n), .start(start), .add(add[i]),
        .retire(sm_done[i]), .close(close[i]), .has_work(has_work),
        .owner(sm_owner[i]), .open(sm_open[i]), .res(res[i])
      );
    end
  endgenerate

  // Kernel arbitration: alternate when both kernels can issue.
  always_comb begin
    disp_valid = any[0] | any[1];
    if (any[0] && any[1]) begin
      disp_kid = prio;
    end else begin
      disp_kid = any[1];
    end
    disp_sm  = disp_kid ? pick[1] : pick[0];
    hs       = disp_valid && disp_ready;
  end

  always_comb begin
    prio_en  = start | hs;
    prio_nxt = prio;
    if (start) begin
      prio_nxt = dsa_pkg::KID_A;
    end else if (hs) begin
      prio_nxt = ~disp_kid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio <= dsa_pkg::KID_A;
    end else if (prio_en) begin
      prio <= prio_nxt;
    end
  end

  assign all_done = (pend[0] == '0) && (pend[1] == '0) && (res_flat == '0);

endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
  parameter int NUM_SM   = 8,
  parameter int SLOT_MAX = 8,
  parameter int CNT_W    = 16,
  parameter int SM_W     = $clog2(NUM_SM),
  parameter int RES_W    = $clog2(SLOT_MAX + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    disp_valid,
  input logic                    disp_ready,
  input logic                    disp_kid,
  input logic [SM_W-1:0]         disp_sm,
  input logic [NUM_SM-1:0]       sm_done,
  input logic [NUM_SM-1:0]       sm_owner,
  input logic [NUM_SM-1:0]       sm_open,
  input logic                    all_done,
  input logic [NUM_SM*RES_W-1:0] res_flat,
  input logic [CNT_W-1:0]        pend_k0,
  input logic [CNT_W-1:0]        pend_k1
);

  logic [RES_W-1:0] res_a [NUM_SM];

  generate
    for (genvar i = 0; i < NUM_SM; i++) begin : g_chk
      assign res_a[i] = res_flat[i*RES_W +: RES_W];

      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        res_a[i] <= RES_W'(SLOT_MAX)); // R2

      AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && disp_sm == SM_W'(i) && sm_done[i] &&
         res_a[i] != '0) |=> $stable(res_a[i])); // R9

      AST_EMPTY_RETIRE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_done[i] && res_a[i] == '0 &&
         !(disp_valid && disp_ready && disp_sm == SM_W'(i))) |=> res_a[i] == '0); // R9
    end
  endgenerate

  AST_DISP_TO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (sm_owner[disp_sm] == disp_kid) && sm_open[disp_sm]); // R3

  AST_DISP_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> res_a[disp_sm] < RES_W'(SLOT_MAX)); // R2

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |-> !disp_valid); // R10

  AST_KEEP_ONE_K0: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_k0 != '0) |-> $countones(~sm_owner & sm_open) >= 1); // R8

  AST_KEEP_ONE_K1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_k1 != '0) |-> $countones(sm_owner & sm_open) >= 1); // R8

endmodule

bind dyn_sm_alloc dsa_checker #(
  .NUM_SM(NUM_SM), .SLOT_MAX(SLOT_MAX), .CNT_W(CNT_W), .SM_W(SM_W), .RES_W(RES_W)
) u_dsa_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_kid(disp_kid), .disp_sm(disp_sm), .sm_done(sm_done),
  .sm_owner(sm_owner), .sm_open(sm_open), .all_done(all_done),
  .res_flat(res_flat), .pend_k0(pend_k0), .pend_k1(pend_k1)
);

// File: tb/dyn_sm_alloc_bench.sv
module dyn_sm_alloc_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] total_k0, total_k1;
  logic        disp_valid, disp_ready, disp_kid;
  logic [2:0]  disp_sm;
  logic [7:0]  sm_done, sm_owner, sm_open;
  logic        all_done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  dyn_sm_alloc u_dyn_sm_alloc (
    .clk(clk), .rst_n(rst_n), .start(start), .total_k0(total_k0),
    .total_k1(total_k1), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_kid(disp_kid), .disp_sm(disp_sm), .sm_done(sm_done),
    .sm_owner(sm_owner), .sm_open(sm_open), .all_done(all_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; disp_ready = 1'b0; sm_done = '0;
    total_k0 = '0; total_k1 = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic do_start(input int a, input int b);
    start = 1'b1; total_k0 = 16'(a); total_k1 = 16'(b);
    step();
    start = 1'b0;
  endtask

  // Full run: bench acts as the SM array, tracking residents from handshakes.
  task automatic run_case(input int a, input int b);
    int res [8];
    int sent [2];
    int tot [2];
    int bad_disp, bad_keep, bad_done, n;
    bit fin;
    do_reset();
    tot[0] = a; tot[1] = b; sent[0] = 0; sent[1] = 0;
    for (int i = 0; i < 8; i++) res[i] = 0;
    bad_disp = 0; bad_keep = 0; bad_done = 0; n = 0; fin = 0;
    do_start(a, b);
    while (!fin && n < 20000) begin
      bit busy;
      busy = (sent[0] != tot[0]) || (sent[1] != tot[1]);
      for (int i = 0; i < 8; i++) if (res[i] != 0) busy = 1;
      if (all_done != !busy) bad_done++;
      for (int k = 0; k < 2; k++) begin
        if (sent[k] < tot[k]) begin
          bit found;
          found = 0;
          for (int i = 0; i < 8; i++)
            if (sm_owner[i] == k[0] && sm_open[i]) found = 1;
          if (!found) bad_keep++;
        end
      end
      for (int i = 0; i < 8; i++)
        sm_done[i] = (res[i] > 0) ? ($urandom % 4 == 0) : ($urandom % 16 == 0);
      disp_ready = ($urandom % 4 != 0);
      #1;
      for (int i = 0; i < 8; i++) if (sm_done[i] && res[i] > 0) res[i]--;
      if (disp_valid && disp_ready) begin
        if (sm_owner[disp_sm] != disp_kid || !sm_open[disp_sm]) bad_disp++;
        if (res[disp_sm] >= 8) bad_disp++;
        if (disp_kid) sent[1]++; else sent[0]++;
        if (sent[disp_kid] > tot[disp_kid]) bad_disp++;
        res[disp_sm]++;
      end
      fin = (sent[0] == tot[0]) && (sent[1] == tot[1]);
      for (int i = 0; i < 8; i++) if (res[i] != 0) fin = 0;
      step();
      n++;
    end
    disp_ready = 1'b0; sm_done = '0;
    step();
    chk(bad_disp == 0, "R2 R3 dispatch legality", bad_disp, 0);
    chk(bad_keep == 0, "R8 open SM kept", bad_keep, 0);
    chk(sent[0] == a && sent[1] == b, "R10 dispatch totals", sent[0] + sent[1], a + b);
    chk(all_done == 1'b1 && bad_done == 0, "R9 R10 done flag", bad_done, 0);
  endtask

  initial begin
    int vals [9];
    vals = '{0, 1, 8, 24, 25, 48, 49, 130, 300};
    rst_n = 1'b1; start = 1'b0; disp_ready = 1'b0; sm_done = '0;
    total_k0 = '0; total_k1 = '0;

    // Reset state
    do_reset();
    chk(sm_owner == 8'hF0, "R1 reset owners", sm_owner, 8'hF0);
    chk(disp_valid == 1'b0, "R1 reset no dispatch", disp_valid, 0);
    chk(all_done == 1'b1, "R10 idle done", all_done, 1);

    // Retire pulses on empty SMs change nothing
    sm_done = 8'hFF;
    step();
    sm_done = '0;
    step();
    chk(all_done == 1'b1, "R9 empty retire ignored", all_done, 1);

    // Threshold shrink from 4 SMs at 48 waiting, then hand-over
    do_start(49, 200);
    disp_ready = 1'b1;
    #1;
    chk(sm_owner == 8'hF0, "R1 start owners", sm_owner, 8'hF0);
    chk(sm_open == 8'hFF, "R1 start all open", sm_open, 8'hFF);
    chk(all_done == 1'b0, "R10 busy not done", all_done, 0);
    chk(disp_valid && disp_kid == 1'b0, "R5 kernel 0 first", disp_kid, 0);
    chk(disp_sm == 3'd0, "R4 first SM of kernel 0", disp_sm, 0);
    step();
    disp_ready = 1'b0;
    chk(sm_open == 8'hFF, "R6 not closed before threshold edge", sm_open, 8'hFF);
    step();
    chk(sm_open == 8'hF7, "R6 highest SM closed at 48", sm_open, 8'hF7);
    step();
    chk(sm_owner == 8'hF8, "R7 drained SM passed over", sm_owner, 8'hF8);
    chk(sm_open == 8'hFF, "R7 passed SM reopened", sm_open, 8'hFF);

    // Alternating priority and round-robin order
    do_reset();
    do_start(100, 100);
    disp_ready = 1'b1;
    #1;
    chk(disp_kid == 1'b0 && disp_sm == 3'd0, "R5 R4 grant 1", {disp_kid, disp_sm}, 0);
    step();
    chk(disp_kid == 1'b1 && disp_sm == 3'd4, "R5 R4 grant 2", {disp_kid, disp_sm}, 12);
    step();
    chk(disp_kid == 1'b0 && disp_sm == 3'd1, "R5 R4 grant 3", {disp_kid, disp_sm}, 1);
    step();
    chk(disp_kid == 1'b1 && disp_sm == 3'd5, "R5 R4 grant 4", {disp_kid, disp_sm}, 13);
    disp_ready = 1'b0;

    // Empty kernel gives all SMs to the busy one
    do_reset();
    do_start(0, 50);
    step();
    chk(sm_open == 8'hF0, "R8 empty kernel closes SMs", sm_open, 8'hF0);
    step();
    chk(sm_owner == 8'hFF && sm_open == 8'hFF, "R7 R8 all SMs to kernel 1", sm_owner, 8'hFF);

    // Zero totals are done at once
    do_reset();
    do_start(0, 0);
    chk(all_done == 1'b1 && disp_valid == 1'b0, "R10 empty load done", all_done, 1);

    // Sweep of total pairs
    foreach (vals[x]) begin
      foreach (vals[y]) begin
        run_case(vals[x], vals[y]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule